// File: doc/BRIEF.md
# Nonvolatile Register Write-Unlock Guard

This block sits between a serial-bus front end and a small bank of nonvolatile clock and control registers. The front end has already turned bit traffic into events: a start condition, a stop condition, a received byte, or an aborted transfer (for example a wrong bit count). The block follows each transaction from these events. It holds two volatile unlock flags: a write-enable flag and a register-write-enable flag. A burst of register writes reaches the storage only when both flags are set. A single status-register write with a specific value sets or clears those flags.

A register burst that is accepted is buffered while it arrives. When a clean stop ends it, the block drains the buffered bytes in address order on a valid/ready commit stream, then counts out a fixed nonvolatile programming time. Once that time has elapsed the register-write-enable flag drops, so the next change needs a fresh unlock. The event input is also a valid/ready stream. The block deasserts `ev_ready` only while the commit stream still has bytes to hand over. Whenever the drain is not running, every event is taken in the cycle it is offered. A commit byte that is offered stays unchanged until the sink accepts it.

Top module: `nvreg_unlock_guard`

## Requirements
- R1: After reset the write-enable flag `wel`, the register-write-enable flag `rwel`, `busy` and `cm_valid` are all 0, and `ev_ready` is 1.
- R2: A write transaction sets `wel` and leaves `rwel` unchanged when it ends with a stop after exactly one data byte of 02h. Such a transaction consists of event kinds (0 start, 1 stop, 2 byte, 3 abort), then the byte DEh, then the status address 3Fh, then the data byte. The new flag value is visible from the clock edge that accepts the stop.
- R3: The same status transaction carrying 06h sets both `wel` and `rwel`, whether or not 02h was written before. `rwel` is never 1 while `wel` is 0.
- R4: A status transaction carrying 00h clears both flags. A status transaction with any other value, or with more or fewer than one data byte, leaves both flags unchanged.
- R5: A register burst is a write transaction whose address byte is below 3Fh. It starts a commit only if `wel` and `rwel` are both 1, it has 1 to MAX_BURST (8) data bytes, and it ends with a stop. Byte i goes to address base+i, and the accepted bytes appear on `cm_addr`/`cm_data` in that order. A burst with no data bytes, with more than MAX_BURST bytes, or sent while `rwel` is 0 starts nothing and leaves the flags unchanged.
- R6: An abort event, or a start event arriving in place of the stop, throws the current transaction away. It commits nothing and leaves both flags unchanged.
- R7: Bytes whose address is BANK_SIZE (20) or above are dropped from the commit stream. The rest of the burst still commits, and the programming time still runs.
- R8: `busy` rises at the edge that accepts a committing stop. It stays high while bytes drain and for NV_CYCLES cycles after the last one. At the edge where it falls, `rwel` clears and `wel` keeps its value.
- R9: A status or register write transaction whose stop is accepted while `busy` is 1 has no effect.
- R10: A transaction whose first byte is not DEh (a read or another target), with its bytes and stop, leaves the flags unchanged, including when it falls between the 02h and 06h steps.
- R11: `ev_ready` is 0 exactly while `cm_valid` is 1. While `cm_valid` is 1 and `cm_ready` is 0, `cm_addr` and `cm_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Bus event offered |
| ev_ready | output | 1 | Event taken at this edge if valid |
| ev_kind | input | 2 | 0 start, 1 stop, 2 byte, 3 abort |
| ev_data | input | 8 | Byte value for kind 2 |
| cm_valid | output | 1 | Commit byte offered to storage |
| cm_ready | input | 1 | Storage accepts the commit byte |
| cm_addr | output | 8 | Register address of the commit byte |
| cm_data | output | 8 | Value of the commit byte |
| wel | output | 1 | Write-enable flag |
| rwel | output | 1 | Register-write-enable flag |
| busy | output | 1 | Drain or programming time in progress |

## Verification
The hardest case to reach is a write transaction whose stop lands inside the busy window. The event stream stalls during the drain, so such a stop can only land in the programming-time part of the window. The stimulus commits a one-byte burst and then at once sends a status clear. The send blocks on `ev_ready` until the drain ends and then completes within the timed window. The expected result is that `wel` survives and only the timed `rwel` clear occurs. A throttled `cm_ready` pattern exercises back-pressure in both directions. A burst that starts just below BANK_SIZE exercises the address filter.

// File: rtl/nug_pkg.sv
package nug_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_BYTE  = 2'd2,
    EV_ABORT = 2'd3
  } ev_kind_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SLAVE,
    TX_ADDR,
    TX_DATA,
    TX_SKIP
  } tx_state_t;

  typedef enum logic [1:0] {
    NV_IDLE,
    NV_DRAIN,
    NV_TIMER
  } nv_state_t;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_wr_t;

  localparam logic [7:0] ST_CLEAR = 8'h00;
  localparam logic [7:0] ST_WEL   = 8'h02;
  localparam logic [7:0] ST_BOTH  = 8'h06;
endpackage

// File: rtl/nug_latches.sv
module nug_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wel,
  input  logic set_both,
  input  logic clr_both,
  input  logic clr_rwel,
  output logic wel,
  output logic rwel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else begin
      if (clr_both) begin
        wel  <= 1'b0;
        rwel <= 1'b0;
      end else if (set_both) begin
        wel  <= 1'b1;
        rwel <= 1'b1;
      end else if (set_wel) begin
        wel <= 1'b1;
      end
      if (clr_rwel) rwel <= 1'b0;
    end
  end
endmodule

// File: rtl/nug_txn_parser.sv
module nug_txn_parser
  import nug_pkg::*;
#(
  parameter int         MAX_BURST   = 8,
  parameter int         BANK_SIZE   = 20,
  parameter logic [7:0] STATUS_ADDR = 8'h3F,
  parameter logic [7:0] WR_SLAVE    = 8'hDE,
  parameter int         CNT_W       = 4,
  parameter int         IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_fire,
  input  logic [1:0]       ev_kind,
  input  logic [7:0]       ev_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             ctl_done,
  output logic             stat_done,
  output logic [CNT_W-1:0] total_cnt,
  output logic [CNT_W-1:0] kept_cnt,
  output logic [7:0]       stat_val,
  output reg_wr_t          rd_entry
);
  localparam logic [CNT_W-1:0] SAT_CNT = CNT_W'(MAX_BURST + 1);
  localparam logic [CNT_W-1:0] LIM_CNT = CNT_W'(MAX_BURST);

  ev_kind_t  kind;
  tx_state_t st;
  logic [7:0] base;
  logic       is_stat;
  logic [8:0] cur_addr;
  logic       keep_byte;
  reg_wr_t    slots [MAX_BURST];

  assign kind     = ev_kind_t'(ev_kind);
  assign cur_addr = {1'b0, base} + 9'(total_cnt);

  // A data byte of a register burst is buffered only when it fits the
  // burst limit and lands on a defined register.
  assign keep_byte = ev_fire && (kind == EV_BYTE) && (st == TX_DATA) && !is_stat
                     && (total_cnt < LIM_CNT) && (cur_addr < 9'(BANK_SIZE));

  assign ctl_done  = ev_fire && (kind == EV_STOP) && (st == TX_DATA) && !is_stat;
  assign stat_done = ev_fire && (kind == EV_STOP) && (st == TX_DATA) && is_stat
                     && (total_cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      base      <= '0;
      is_stat   <= 1'b0;
      total_cnt <= '0;
      kept_cnt  <= '0;
      stat_val  <= '0;
    end else if (ev_fire) begin
      unique case (kind)
        EV_START: st <= TX_SLAVE;
        EV_ABORT: st <= TX_IDLE;
        EV_STOP:  st <= TX_IDLE;
        EV_BYTE: begin
          unique case (st)
            TX_SLAVE: st <= (ev_data == WR_SLAVE) ? TX_ADDR : TX_SKIP;
            TX_ADDR: begin
              base      <= ev_data;
              is_stat   <= (ev_data == STATUS_ADDR);
              total_cnt <= '0;
              kept_cnt  <= '0;
              st        <= TX_DATA;
            end
            TX_DATA: begin
              if (total_cnt == '0) stat_val <= ev_data;
              if (total_cnt != SAT_CNT) total_cnt <= total_cnt + 1'b1;
              if (keep_byte) kept_cnt <= kept_cnt + 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_BURST; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (keep_byte && (kept_cnt == CNT_W'(g))) begin
        slots[g] <= '{addr: cur_addr[7:0], data: ev_data};
      end
    end
  end

  assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/nug_commit_engine.sv
module nug_commit_engine
  import nug_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter int NV_CYCLES = 2_500_000,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] kept_cnt,
  input  reg_wr_t          rd_entry,
  input  logic             cm_ready,
  output logic [IDX_W-1:0] rd_idx,
  output logic             cm_valid,
  output logic [7:0]       cm_addr,
  output logic [7:0]       cm_data,
  output logic             busy,
  output logic             cycle_done
);
  localparam int TMR_W = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(NV_CYCLES - 1);

  nv_state_t        st;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= NV_IDLE;
      idx  <= '0;
      last <= '0;
      tmr  <= '0;
    end else begin
      unique case (st)
        NV_IDLE: begin
          if (go) begin
            if (kept_cnt == '0) begin
              st  <= NV_TIMER;
              tmr <= TMR_LOAD;
            end else begin
              st   <= NV_DRAIN;
              idx  <= '0;
              last <= IDX_W'(kept_cnt - 1'b1);
            end
          end
        end
        NV_DRAIN: begin
          if (cm_ready) begin
            if (idx == last) begin
              st  <= NV_TIMER;
              tmr <= TMR_LOAD;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        NV_TIMER: begin
          if (tmr == '0) st <= NV_IDLE;
          else tmr <= tmr - 1'b1;
        end
        default: st <= NV_IDLE;
      endcase
    end
  end

  assign rd_idx     = idx;
  assign cm_valid   = (st == NV_DRAIN);
  assign cm_addr    = rd_entry.addr;
  assign cm_data    = rd_entry.data;
  assign busy       = (st != NV_IDLE);
  assign cycle_done = (st == NV_TIMER) && (tmr == '0);
endmodule

// File: rtl/nvreg_unlock_guard.sv
module nvreg_unlock_guard
  import nug_pkg::*;
#(
  parameter int         MAX_BURST   = 8,
  parameter int         BANK_SIZE   = 20,
  parameter logic [7:0] STATUS_ADDR = 8'h3F,
  parameter logic [7:0] WR_SLAVE    = 8'hDE,
  parameter int         NV_CYCLES   = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [1:0] ev_kind,
  input  logic [7:0] ev_data,
  output logic       cm_valid,
  input  logic       cm_ready,
  output logic [7:0] cm_addr,
  output logic [7:0] cm_data,
  output logic       wel,
  output logic       rwel,
  output logic       busy
);
  localparam int CNT_W = $clog2(MAX_BURST + 2);
  localparam int IDX_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  logic             ev_fire;
  logic             ctl_done, stat_done;
  logic [CNT_W-1:0] total_cnt, kept_cnt;
  logic [7:0]       stat_val;
  reg_wr_t          rd_entry;
  logic [IDX_W-1:0] rd_idx;
  logic             cycle_done;
  logic             stat_ok, go;

  assign ev_ready = !cm_valid;
  assign ev_fire  = ev_valid && ev_ready;

  assign stat_ok = stat_done && !busy;
  assign go      = ctl_done && !busy && wel && rwel
                   && (total_cnt != '0) && (total_cnt <= CNT_W'(MAX_BURST));

  nug_txn_parser #(
    .MAX_BURST(MAX_BURST), .BANK_SIZE(BANK_SIZE), .STATUS_ADDR(STATUS_ADDR),
    .WR_SLAVE(WR_SLAVE), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_parser (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_kind(ev_kind),
    .ev_data(ev_data), .rd_idx(rd_idx), .ctl_done(ctl_done),
    .stat_done(stat_done), .total_cnt(total_cnt), .kept_cnt(kept_cnt),
    .stat_val(stat_val), .rd_entry(rd_entry)
  );

  nug_commit_engine #(
    .MAX_BURST(MAX_BURST), .NV_CYCLES(NV_CYCLES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .kept_cnt(kept_cnt),
    .rd_entry(rd_entry), .cm_ready(cm_ready), .rd_idx(rd_idx),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data),
    .busy(busy), .cycle_done(cycle_done)
  );

  nug_latches u_latches (
    .clk(clk), .rst_n(rst_n),
    .set_wel(stat_ok && (stat_val == ST_WEL)),
    .set_both(stat_ok && (stat_val == ST_BOTH)),
    .clr_both(stat_ok && (stat_val == ST_CLEAR)),
    .clr_rwel(cycle_done),
    .wel(wel), .rwel(rwel)
  );
endmodule

// File: rtl/nug_checker.sv
module nug_checker #(
  parameter int BANK_SIZE = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_ready,
  input logic       cm_valid,
  input logic       cm_ready,
  input logic [7:0] cm_addr,
  input logic [7:0] cm_data,
  input logic       wel,
  input logic       rwel,
  input logic       busy
);
  assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_commit_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && $past(rwel)));

  assert_defined_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_addr < 8'(BANK_SIZE)));

  assert_rwel_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rwel) |-> ($fell(busy) || !wel));

  assert_wel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wel));

  assert_drain_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (!ev_ready && busy));

  assert_hold_payload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr) && $stable(cm_data)));
endmodule

bind nvreg_unlock_guard nug_checker #(.BANK_SIZE(BANK_SIZE)) u_nug_checker (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .cm_valid(cm_valid),
  .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data),
  .wel(wel), .rwel(rwel), .busy(busy)
);

// File: tb/nvreg_unlock_guard_test.sv
`timescale 1ns/1ps
module nvreg_unlock_guard_test;
  localparam int NV   = 40;
  localparam int BANK = 20;
  localparam int MAXB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_data = 8'd0;
  logic cm_ready = 1'b1;
  logic ev_ready, cm_valid, wel, rwel, busy;
  logic [7:0] cm_addr, cm_data;

  always #2 clk = ~clk;

  nvreg_unlock_guard #(.MAX_BURST(MAXB), .BANK_SIZE(BANK), .NV_CYCLES(NV)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_data(ev_data), .cm_valid(cm_valid),
    .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data),
    .wel(wel), .rwel(rwel), .busy(busy)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit thr = 0;

  // behavioural reference model
  int m_tx = 0, m_base = 0, m_total = 0, m_sval = 0;
  bit m_isst = 0, m_wel = 0, m_rwel = 0;
  int m_phase = 0, m_cnt = 0, m_emit = 0;
  int ka[$], kd[$], da[$], dd[$];

  function automatic void chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  function automatic void model_step();
    bit ob = (m_phase != 0);
    bit ow = m_wel;
    bit orw = m_rwel;
    bit acc = ev_valid && (m_phase != 1);
    if (m_phase == 1) begin
      if (cm_ready) begin
        void'(da.pop_front()); void'(dd.pop_front()); m_emit++;
        if (da.size() == 0) begin m_phase = 2; m_cnt = NV - 1; end
      end
    end else if (m_phase == 2) begin
      if (m_cnt == 0) begin m_phase = 0; m_rwel = 0; end
      else m_cnt--;
    end
    if (acc) begin
      case (ev_kind)
        2'd0: m_tx = 1;
        2'd3: m_tx = 0;
        2'd1: begin
          if (m_tx == 3) begin
            if (m_isst) begin
              if (m_total == 1 && !ob) begin
                if (m_sval == 0) begin m_wel = 0; m_rwel = 0; end
                else if (m_sval == 2) m_wel = 1;
                else if (m_sval == 6) begin m_wel = 1; m_rwel = 1; end
              end
            end else if (!ob && ow && orw && m_total >= 1 && m_total <= MAXB) begin
              da = ka; dd = kd;
              if (ka.size() == 0) begin m_phase = 2; m_cnt = NV - 1; end
              else m_phase = 1;
            end
          end
          m_tx = 0;
        end
        default: begin
          case (m_tx)
            1: m_tx = (ev_data == 8'hDE) ? 2 : 4;
            2: begin
              m_base = ev_data; m_total = 0; m_isst = (ev_data == 8'h3F);
              ka.delete(); kd.delete(); m_tx = 3;
            end
            3: begin
              if (m_total == 0) m_sval = ev_data;
              if (!m_isst && m_total < MAXB && m_base + m_total < BANK) begin
                ka.push_back(m_base + m_total); kd.push_back(ev_data);
              end
              if (m_total < MAXB + 1) m_total++;
            end
            default: ;
          endcase
        end
      endcase
    end
  endfunction

  task automatic tick();
    cyc++;
    cm_ready = thr ? (cyc % 3 == 1) : 1'b1;
    #1;
    chk(wel, m_wel, "R2 wel");
    chk(rwel, m_rwel, "R3 rwel");
    chk(busy, m_phase != 0, "R8 busy");
    chk(ev_ready, m_phase != 1, "R11 ev_ready");
    chk(cm_valid, m_phase == 1, "R5 cm_valid");
    if (m_phase == 1 && cm_valid) begin
      chk(cm_addr, da[0], "R7 cm_addr");
      chk(cm_data, dd[0], "R5 cm_data");
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] d);
    bit took = 0;
    ev_valid = 1'b1; ev_kind = k; ev_data = d;
    while (!took) begin
      took = (m_phase != 1);
      tick();
    end
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && m_phase != 0; i++) tick();
  endtask

  task automatic wr_status(input logic [7:0] v);
    send(2'd0, 8'h00); send(2'd2, 8'hDE); send(2'd2, 8'h3F);
    send(2'd2, v); send(2'd1, 8'h00);
  endtask

  // end_kind: 1 stop, 3 abort, 0 repeated start
  task automatic wr_burst(input logic [7:0] a, input int n, input logic [7:0] seed,
                          input logic [1:0] end_kind);
    send(2'd0, 8'h00); send(2'd2, 8'hDE); send(2'd2, a);
    for (int i = 0; i < n; i++) send(2'd2, seed + 8'(i * 7));
    send(end_kind, 8'h00);
  endtask

  task automatic rd_txn();
    send(2'd0, 8'h00); send(2'd2, 8'hDF); send(2'd2, 8'h55);
    send(2'd2, 8'h3F); send(2'd1, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(wel, 0, "R1 reset wel"); chk(rwel, 0, "R1 reset rwel");
    chk(busy, 0, "R1 reset busy"); chk(cm_valid, 0, "R1 reset cm_valid");
    chk(ev_ready, 1, "R1 reset ev_ready");
    @(negedge clk);
    idle(2);

    wr_status(8'h02); idle(1);
    chk(wel, 1, "R2 02h sets wel"); chk(rwel, 0, "R2 02h leaves rwel");
    wr_status(8'h06); idle(1);
    chk(rwel, 1, "R3 06h sets rwel");
    wr_status(8'h00); idle(1);
    chk(wel, 0, "R4 00h clears wel"); chk(rwel, 0, "R4 00h clears rwel");
    wr_status(8'h06); idle(1);
    chk(wel, 1, "R3 06h alone sets wel"); chk(rwel, 1, "R3 06h alone sets rwel");
    wr_status(8'h04); idle(1);
    chk(rwel, 1, "R4 other value ignored");
    wr_burst(8'h3F, 2, 8'h00, 2'd1); idle(1);
    chk(rwel, 1, "R4 two-byte status ignored");

    // clean commit
    e0 = m_emit;
    wr_burst(8'd2, 3, 8'h11, 2'd1);
    chk(busy, 1, "R8 busy after commit stop");
    wait_idle();
    chk(m_emit - e0, 3, "R5 three bytes committed");
    chk(rwel, 0, "R8 rwel cleared at end"); chk(wel, 1, "R8 wel kept");

    // locked burst
    wr_burst(8'd1, 2, 8'h20, 2'd1); idle(1);
    chk(busy, 0, "R5 no commit with rwel clear");

    // read between unlock steps
    wr_status(8'h00); wr_status(8'h02); rd_txn(); wr_status(8'h06); idle(1);
    chk(rwel, 1, "R10 read between unlock steps");
    rd_txn(); idle(1);
    chk(wel, 1, "R10 read keeps wel");

    // oversize, aborts, repeated start, empty burst
    wr_burst(8'd0, 9, 8'h30, 2'd1); idle(1);
    chk(busy, 0, "R5 nine bytes rejected"); chk(rwel, 1, "R5 oversize keeps rwel");
    wr_burst(8'd0, 2, 8'h40, 2'd3); idle(1);
    chk(busy, 0, "R6 abort no commit"); chk(rwel, 1, "R6 abort keeps rwel");
    wr_burst(8'd0, 2, 8'h50, 2'd0);
    send(2'd2, 8'hDF); send(2'd1, 8'h00); idle(1);
    chk(busy, 0, "R6 start in place of stop"); chk(rwel, 1, "R6 restart keeps rwel");
    wr_burst(8'd5, 0, 8'h00, 2'd1); idle(1);
    chk(busy, 0, "R5 empty burst no commit");

    // burst crossing end of bank under back-pressure
    thr = 1; e0 = m_emit;
    wr_burst(8'd17, 5, 8'h60, 2'd1);
    wait_idle();
    chk(m_emit - e0, 3, "R7 undefined addresses dropped");
    chk(rwel, 0, "R8 rwel cleared after filtered burst");

    // full burst with throttling
    wr_status(8'h06); e0 = m_emit;
    wr_burst(8'd0, 8, 8'h70, 2'd1);
    send(2'd0, 8'h00);
    chk(busy, 1, "R11 event waited for drain");
    send(2'd3, 8'h00);
    wait_idle();
    chk(m_emit - e0, 8, "R5 eight bytes committed");
    thr = 0;

    // writes during busy are rejected
    wr_status(8'h06);
    wr_burst(8'd0, 1, 8'h80, 2'd1);
    wr_status(8'h00);
    chk(busy, 1, "R9 stop landed while busy");
    wr_status(8'h06);
    wait_idle();
    chk(wel, 1, "R9 clear during busy ignored");
    chk(rwel, 0, "R9 06h during busy ignored");
    idle(3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule